// File: doc/BRIEF.md
# IDE Timing Register Window

This block is the register front end of a legacy IDE host port whose eight-address I/O window is shared by two register sets. After reset the window serves a stand-in task-file register file. A fixed host access sequence opens a hidden bank of timing control registers in the same eight addresses. While that bank is open, the task-file registers cannot be reached. A relock write closes the bank and brings the task-file registers back, with their contents intact.

In control mode, software first selects a drive with bit 0 of a select register and writes that drive's read-cycle and write-cycle timing bytes into a staging area. It then writes a shared address-setup value into the upper bits of the same select register. A commit code written to the control register copies the staged values to the latched timing sets. The cycle generator reads those sets: set 0 for drive 0 and set 1 for drive 1. A read-only strap register reports the bus clock strap taken from an input pin.

Host reads return data one cycle after the access. The committed timing sets, the mode flag and the strap bit are driven out continuously.

Top module: `ide_timing_window`

## Requirements
- R1: After reset the window is in task-file mode (`ctrl_mode` = 0), `rd_valid` is 0, all four timing outputs equal `SLOW_TIMING` (0xFF) and `addr_setup` equals `SLOW_SETUP` (0x7F).
- R2: In task-file mode, a halfword read at offset 1, then another halfword read at offset 1, then a byte write of 0x03 to offset 2 sets `ctrl_mode` to 1 on the clock edge that takes the write.
- R3: Any access in task-file mode that is not the next expected step returns the sequence tracker to idle. This covers a wrong offset, a byte-width read, a halfword-width write and a value other than 0x03. Consecutive halfword reads at offset 1 count as the two reads, however many there are.
- R4: In task-file mode, accesses reach an 8-entry, 16-bit stand-in register file. A halfword write stores all 16 bits. A byte write replaces only bits 7:0. A halfword read returns all 16 bits, and a byte read returns bits 7:0 with zeros above. Every read raises `rd_valid` with the data exactly one cycle later, and no other access raises it.
- R5: Writes made in control mode never change the task-file registers. After a relock, those registers read back the values they held before the unlock.
- R6: In control mode, bit 0 of the select register at offset 6 picks the drive. Writes to offset 0 (read timing) and offset 1 (write timing) go to that drive's staged set, and reads of offsets 0 and 1 return that drive's staged values.
- R7: A write of 0x85 to the control register at offset 3 copies both staged sets to the timing outputs on the next edge. It also copies bits 7:1 of the select register to `addr_setup`. Any other value written there is stored and reads back, and it leaves the outputs unchanged.
- R8: A read of offset 5 in control mode returns `strap_in` in bit 0, where 0 means a 33 MHz bus clock and 1 means 25 MHz, with zeros above. Writes to offset 5 are ignored. `strap_clk25` follows `strap_in`.
- R9: In control mode, reads of offsets 2, 4 and 7 return zero.
- R10: In control mode, a byte write of 0x83 to offset 2 sets `ctrl_mode` to 0 on that edge. Other values written to offset 2 have no effect.
- R11: Staged timing values do not reach the timing outputs until a commit, and committed values stay in place across a relock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_half | input | 1 | 1 = halfword access, 0 = byte access |
| acc_offs | input | 3 | Offset within the window |
| acc_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| strap_in | input | 1 | Bus clock strap pin (1 = 25 MHz) |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 16 | Read data |
| ctrl_mode | output | 1 | 1 = control bank open |
| strap_clk25 | output | 1 | Strap bit as seen by the bank |
| drv0_rd_timing | output | 8 | Committed read-cycle timing, drive 0 |
| drv0_wr_timing | output | 8 | Committed write-cycle timing, drive 0 |
| drv1_rd_timing | output | 8 | Committed read-cycle timing, drive 1 |
| drv1_wr_timing | output | 8 | Committed write-cycle timing, drive 1 |
| addr_setup | output | 7 | Committed shared address-setup value |

## Verification
Each result appears one clock edge after the access that causes it. This holds for read data with `rd_valid`, for the mode change on an unlock or relock write, and for the new timing outputs after a commit write. The bench drives each access on a falling edge and holds it through one rising edge. It then checks the mode flag and the timing outputs at the next falling edge. Expected read data goes into a queue when the read is issued, and a monitor compares it at the falling edge where `rd_valid` is high. Any read data left over or missing is a failure.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    parameter int OFFS_W  = 3;
    parameter int DATA_W  = 16;
    parameter int TW      = 8;
    parameter int NDRV    = 2;
    localparam int SEL_W   = (NDRV > 1) ? $clog2(NDRV) : 1;
    localparam int SETUP_W = TW - SEL_W;
    localparam int DEPTH   = 1 << OFFS_W;

    localparam logic [OFFS_W-1:0] OFF_RDT   = 3'd0;
    localparam logic [OFFS_W-1:0] OFF_WRT   = 3'd1;
    localparam logic [OFFS_W-1:0] OFF_KEY   = 3'd2;
    localparam logic [OFFS_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [OFFS_W-1:0] OFF_STRAP = 3'd5;
    localparam logic [OFFS_W-1:0] OFF_MISC  = 3'd6;

    localparam logic [TW-1:0] KEY_OPEN    = 8'h03;
    localparam logic [TW-1:0] KEY_CLOSE   = 8'h83;
    localparam logic [TW-1:0] CTRL_COMMIT = 8'h85;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_e;

    typedef struct packed {
        logic [TW-1:0] rd;
        logic [TW-1:0] wr;
    } tset_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              half;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] wdata;
    } hacc_t;

    function automatic logic is_seq_read(hacc_t a);
        return a.valid && !a.write && a.half && (a.offs == OFF_WRT);
    endfunction

    function automatic logic is_key_write(hacc_t a, logic [TW-1:0] key);
        return a.valid && a.write && !a.half && (a.offs == OFF_KEY)
               && (a.wdata[TW-1:0] == key);
    endfunction

endpackage

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
    import ide_win_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hacc_t acc,
    output logic  ctrl_mode
);

    seq_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            ctrl_mode <= 1'b0;
        end else if (acc.valid) begin
            if (!ctrl_mode) begin
                if (is_seq_read(acc)) begin
                    state <= (state == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
                end else if ((state == SEQ_TWO) && is_key_write(acc, KEY_OPEN)) begin
                    state     <= SEQ_IDLE;
                    ctrl_mode <= 1'b1;
                end else begin
                    state <= SEQ_IDLE;
                end
            end else begin
                state <= SEQ_IDLE;
                if (is_key_write(acc, KEY_CLOSE)) begin
                    ctrl_mode <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/ide_taskfile_stub.sv
module ide_taskfile_stub
    import ide_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  hacc_t             acc,
    output logic [DATA_W-1:0] rdata
);

    localparam int LOW_W = TW;

    logic [DATA_W-1:0] regs [DEPTH];
    logic [DATA_W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (en && acc.valid && acc.write) begin
            if (acc.half) regs[acc.offs] <= acc.wdata;
            else          regs[acc.offs][LOW_W-1:0] <= acc.wdata[LOW_W-1:0];
        end
    end

    assign cur   = regs[acc.offs];
    assign rdata = acc.half ? cur : {{(DATA_W-LOW_W){1'b0}}, cur[LOW_W-1:0]};

endmodule

// File: rtl/ide_ctrl_bank.sv
module ide_ctrl_bank
    import ide_win_pkg::*;
#(
    parameter logic [TW-1:0]      SLOW_TIMING = 8'hFF,
    parameter logic [SETUP_W-1:0] SLOW_SETUP  = 7'h7F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  hacc_t              acc,
    input  logic               strap_in,
    output logic [DATA_W-1:0]  rdata,
    output tset_t [NDRV-1:0]   live,
    output logic [SETUP_W-1:0] setup
);

    tset_t [NDRV-1:0] stg;
    logic [TW-1:0]    misc_q;
    logic [TW-1:0]    ctrl_q;
    logic [SEL_W-1:0] sel;
    logic             wr_hit;
    logic             commit;
    logic [TW-1:0]    byte_rd;

    assign sel    = misc_q[SEL_W-1:0];
    assign wr_hit = en && acc.valid && acc.write;
    assign commit = wr_hit && (acc.offs == OFF_CTRL) && (acc.wdata[TW-1:0] == CTRL_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_q <= '0;
            ctrl_q <= '0;
        end else if (wr_hit) begin
            if (acc.offs == OFF_MISC) misc_q <= acc.wdata[TW-1:0];
            if (acc.offs == OFF_CTRL) ctrl_q <= acc.wdata[TW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NDRV; d++) begin
                stg[d].rd <= SLOW_TIMING;
                stg[d].wr <= SLOW_TIMING;
            end
        end else if (wr_hit) begin
            for (int d = 0; d < NDRV; d++) begin
                if (sel == SEL_W'(d)) begin
                    if (acc.offs == OFF_RDT) stg[d].rd <= acc.wdata[TW-1:0];
                    if (acc.offs == OFF_WRT) stg[d].wr <= acc.wdata[TW-1:0];
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NDRV; g++) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    live[g].rd <= SLOW_TIMING;
                    live[g].wr <= SLOW_TIMING;
                end else if (commit) begin
                    live[g] <= stg[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         setup <= SLOW_SETUP;
        else if (commit) setup <= misc_q[TW-1:SEL_W];
    end

    always_comb begin
        case (acc.offs)
            OFF_RDT:   byte_rd = stg[sel].rd;
            OFF_WRT:   byte_rd = stg[sel].wr;
            OFF_CTRL:  byte_rd = ctrl_q;
            OFF_STRAP: byte_rd = {{(TW-1){1'b0}}, strap_in};
            OFF_MISC:  byte_rd = misc_q;
            default:   byte_rd = '0;
        endcase
    end

    assign rdata = {{(DATA_W-TW){1'b0}}, byte_rd};

endmodule

// File: rtl/ide_timing_window.sv
module ide_timing_window
    import ide_win_pkg::*;
#(
    parameter logic [TW-1:0]      SLOW_TIMING = 8'hFF,
    parameter logic [SETUP_W-1:0] SLOW_SETUP  = 7'h7F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_half,
    input  logic [OFFS_W-1:0]  acc_offs,
    input  logic [DATA_W-1:0]  acc_wdata,
    input  logic               strap_in,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ctrl_mode,
    output logic               strap_clk25,
    output logic [TW-1:0]      drv0_rd_timing,
    output logic [TW-1:0]      drv0_wr_timing,
    output logic [TW-1:0]      drv1_rd_timing,
    output logic [TW-1:0]      drv1_wr_timing,
    output logic [SETUP_W-1:0] addr_setup
);

    hacc_t             acc;
    logic [DATA_W-1:0] tf_rdata;
    logic [DATA_W-1:0] bank_rdata;
    tset_t [NDRV-1:0]  live;

    assign acc = '{valid: acc_valid, write: acc_write, half: acc_half,
                   offs: acc_offs, wdata: acc_wdata};

    ide_unlock_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .ctrl_mode (ctrl_mode)
    );

    ide_taskfile_stub u_tf (
        .clk   (clk),
        .rst   (rst),
        .en    (!ctrl_mode),
        .acc   (acc),
        .rdata (tf_rdata)
    );

    ide_ctrl_bank #(
        .SLOW_TIMING (SLOW_TIMING),
        .SLOW_SETUP  (SLOW_SETUP)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_mode),
        .acc      (acc),
        .strap_in (strap_in),
        .rdata    (bank_rdata),
        .live     (live),
        .setup    (addr_setup)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write)
                rd_data <= ctrl_mode ? bank_rdata : tf_rdata;
        end
    end

    assign strap_clk25    = strap_in;
    assign drv0_rd_timing = live[0].rd;
    assign drv0_wr_timing = live[0].wr;
    assign drv1_rd_timing = live[1].rd;
    assign drv1_wr_timing = live[1].wr;

endmodule

// File: rtl/ide_timing_window_chk.sv
module ide_timing_window_chk
    import ide_win_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               acc_half,
    input logic [OFFS_W-1:0]  acc_offs,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic               strap_in,
    input logic               rd_valid,
    input logic [DATA_W-1:0]  rd_data,
    input logic               ctrl_mode,
    input logic [TW-1:0]      drv0_rd_timing,
    input logic [TW-1:0]      drv0_wr_timing,
    input logic [TW-1:0]      drv1_rd_timing,
    input logic [TW-1:0]      drv1_wr_timing,
    input logic [SETUP_W-1:0] addr_setup
);

    logic open_wr, close_wr, commit_wr, rd_acc;
    assign open_wr   = acc_valid && acc_write && !acc_half && acc_offs == OFF_KEY && acc_wdata[7:0] == 8'h03;
    assign close_wr  = acc_valid && acc_write && !acc_half && acc_offs == OFF_KEY && acc_wdata[7:0] == 8'h83;
    assign commit_wr = acc_valid && acc_write && ctrl_mode && acc_offs == OFF_CTRL && acc_wdata[7:0] == 8'h85;
    assign rd_acc    = acc_valid && !acc_write;

    AST_OPEN_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_mode) |-> $past(open_wr)); // R2

    AST_CLOSE_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_mode) |-> $past(close_wr)); // R10

    AST_TIMING_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(commit_wr) |-> ($stable(drv0_rd_timing) && $stable(drv0_wr_timing)
            && $stable(drv1_rd_timing) && $stable(drv1_wr_timing) && $stable(addr_setup))); // R7

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rd_valid); // R4

    AST_NO_STRAY_DATA: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> !rd_valid); // R4

    AST_STRAP_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && ctrl_mode && acc_offs == OFF_STRAP) |=> (rd_data == {15'b0, $past(strap_in)})); // R8

    AST_HOLES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && ctrl_mode && (acc_offs == 3'd2 || acc_offs == 3'd4 || acc_offs == 3'd7))
        |=> (rd_data == '0)); // R9

endmodule

bind ide_timing_window ide_timing_window_chk u_chk (.*);

// File: tb/tb_ide_timing_window.sv
`timescale 1ns/1ps
module tb_ide_timing_window;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_half = 1'b0;
    logic [2:0]  acc_offs = '0;
    logic [15:0] acc_wdata = '0;
    logic        strap_in = 1'b0;
    logic        rd_valid, ctrl_mode, strap_clk25;
    logic [15:0] rd_data;
    logic [7:0]  d0r, d0w, d1r, d1w;
    logic [6:0]  addr_setup;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] tf [8];
    bit          locked_model = 1;

    always #5 clk = ~clk;

    ide_timing_window dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_half(acc_half), .acc_offs(acc_offs), .acc_wdata(acc_wdata),
        .strap_in(strap_in), .rd_valid(rd_valid), .rd_data(rd_data),
        .ctrl_mode(ctrl_mode), .strap_clk25(strap_clk25),
        .drv0_rd_timing(d0r), .drv0_wr_timing(d0w),
        .drv1_rd_timing(d1r), .drv1_wr_timing(d1w), .addr_setup(addr_setup)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when read data appears
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4: actual unexpected read data %h expected none", rd_data);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    // driver: one access, held over one rising edge, returns at the next falling edge
    task automatic access(bit w, bit h, logic [2:0] o, logic [15:0] d);
        acc_valid = 1; acc_write = w; acc_half = h; acc_offs = o; acc_wdata = d;
        if (w && locked_model) begin
            if (h) tf[o] = d;
            else   tf[o][7:0] = d[7:0];
        end
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(bit h, logic [2:0] o, logic [15:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(0, h, o, 16'h0);
    endtask

    task automatic tf_rd(bit h, logic [2:0] o, string tag);
        rd(h, o, h ? tf[o] : {8'h0, tf[o][7:0]}, tag);
    endtask

    task automatic wr(bit h, logic [2:0] o, logic [15:0] d);
        access(1, h, o, d);
    endtask

    task automatic chk_timing(string tag, logic [7:0] a, b, c, e, logic [6:0] s);
        chk(tag, {8'h0, d0r}, {8'h0, a});
        chk(tag, {8'h0, d0w}, {8'h0, b});
        chk(tag, {8'h0, d1r}, {8'h0, c});
        chk(tag, {8'h0, d1w}, {8'h0, e});
        chk(tag, {9'h0, addr_setup}, {9'h0, s});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) tf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", {15'h0, ctrl_mode}, 16'h0);
        chk("R1", {15'h0, rd_valid}, 16'h0);
        chk_timing("R1", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 7'h7F);

        // R4 task-file stand-in
        wr(1, 3'd3, 16'hABCD);
        wr(0, 3'd3, 16'h7712);
        tf_rd(1, 3'd3, "R4");
        tf_rd(0, 3'd3, "R4");
        wr(1, 3'd4, 16'h5A5A);
        wr(1, 3'd0, 16'h1234);
        tf_rd(1, 3'd4, "R4");

        // R3 broken sequences
        tf_rd(1, 3'd1, "R3"); tf_rd(0, 3'd1, "R3"); tf_rd(1, 3'd1, "R3");
        wr(0, 3'd2, 16'h0003);
        chk("R3 width", {15'h0, ctrl_mode}, 16'h0);
        tf_rd(1, 3'd1, "R3"); tf_rd(1, 3'd1, "R3");
        wr(0, 3'd2, 16'h0004);
        wr(0, 3'd2, 16'h0003);
        chk("R3 value", {15'h0, ctrl_mode}, 16'h0);
        tf_rd(1, 3'd1, "R3"); tf_rd(1, 3'd2, "R3"); tf_rd(1, 3'd1, "R3");
        wr(0, 3'd2, 16'h0003);
        chk("R3 offset", {15'h0, ctrl_mode}, 16'h0);
        tf_rd(1, 3'd1, "R3"); tf_rd(1, 3'd1, "R3");
        wr(1, 3'd2, 16'h0003);
        chk("R3 halfwrite", {15'h0, ctrl_mode}, 16'h0);

        // R2 unlock (three reads saturate, R3)
        tf_rd(1, 3'd1, "R2"); tf_rd(1, 3'd1, "R2"); tf_rd(1, 3'd1, "R2");
        wr(0, 3'd2, 16'h0003);
        locked_model = 0;
        chk("R2 unlock", {15'h0, ctrl_mode}, 16'h1);

        // R6 staging per drive
        wr(0, 3'd6, 16'h0000);
        wr(0, 3'd0, 16'h0059);
        wr(0, 3'd1, 16'h0046);
        wr(0, 3'd6, 16'h0001);
        wr(0, 3'd0, 16'h0030);
        wr(0, 3'd1, 16'h0020);
        rd(0, 3'd0, 16'h0030, "R6");
        rd(1, 3'd1, 16'h0020, "R6");
        wr(0, 3'd6, 16'h0000);
        rd(0, 3'd0, 16'h0059, "R6");
        rd(0, 3'd1, 16'h0046, "R6");
        wr(0, 3'd6, 16'h0021);
        rd(0, 3'd6, 16'h0021, "R6");
        chk_timing("R11 staged", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 7'h7F);

        // R7 non-commit then commit
        wr(0, 3'd3, 16'h0084);
        chk_timing("R7 nocommit", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 7'h7F);
        rd(0, 3'd3, 16'h0084, "R7");
        wr(0, 3'd3, 16'h0085);
        chk_timing("R7 commit", 8'h59, 8'h46, 8'h30, 8'h20, 7'h10);

        // R8 strap
        strap_in = 1;
        #1 chk("R8 pin", {15'h0, strap_clk25}, 16'h1);
        rd(0, 3'd5, 16'h0001, "R8");
        wr(0, 3'd5, 16'h00FE);
        rd(1, 3'd5, 16'h0001, "R8");
        strap_in = 0;
        rd(0, 3'd5, 16'h0000, "R8");

        // R9 holes, R5 hidden task file, R10 non-relock write at offset 2
        wr(1, 3'd4, 16'hFFFF);
        wr(0, 3'd7, 16'h00AA);
        rd(0, 3'd2, 16'h0000, "R9");
        rd(1, 3'd4, 16'h0000, "R9");
        rd(0, 3'd7, 16'h0000, "R9");
        wr(0, 3'd2, 16'h0003);
        chk("R10 other value", {15'h0, ctrl_mode}, 16'h1);

        // R10 relock
        wr(0, 3'd2, 16'h0083);
        locked_model = 1;
        chk("R10 relock", {15'h0, ctrl_mode}, 16'h0);
        tf_rd(1, 3'd4, "R5");
        tf_rd(1, 3'd0, "R5");
        tf_rd(1, 3'd3, "R5");
        tf_rd(1, 3'd7, "R5");
        chk_timing("R11 persist", 8'h59, 8'h46, 8'h30, 8'h20, 7'h10);

        repeat (2) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4: actual %0d reads unanswered expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule